// File: doc/BRIEF.md
# Ordered Dial Lock Controller

This block decides whether a dial lock may open. The dial logic outside it reports each finished turn as one strobe cycle, together with the turn direction and the number the dial stopped on. The controller keeps a two-bit record of how far the user has progressed through a fixed three-step secret. The secret is a right turn to 13, then a left turn to 22, then a right turn to 3. When the last step lands, the controller raises a level that stays high until a relock request arrives.

The order of the steps and the direction of each turn both count. Dialling the right numbers in a different order, or with a turn in the wrong direction, sends the record back to the locked idle state. The controller only acts on strobe cycles. Between strobes, the direction and value inputs may carry anything. The secret is held in parameters and cannot be changed at run time.

Top module: `dial_lock_ctrl`

## Requirements
- R1: A synchronous active-high `rst` puts the controller in the locked idle state, so `unlocked` is 0 in the cycle after the reset edge.
- R2: An operation is one cycle with `op_done`=1. `op_dir`=1 means a right turn and 0 means a left turn. `op_val` is a 6-bit unsigned dial number. The three operations right-13, left-22, right-3, given in that order from the idle state, set `unlocked` to 1 in the cycle after the third strobe.
- R3: The three correct steps given in any other order never set `unlocked`.
- R4: A step with the correct value but the opposite direction counts as a mismatch.
- R5: A mismatching operation after one or two correct steps returns the controller to idle. A full new sequence is then needed to open.
- R6: A mismatching operation in the idle state leaves it idle.
- R7: While `op_done`=0, `op_dir` and `op_val` have no effect on progress or on `unlocked`.
- R8: Once open, further operations of any kind leave `unlocked` at 1.
- R9: `relock`=1 returns the controller to idle from any state on the next edge, and wins over an operation strobed in the same cycle.
- R10: `unlocked` is 1 only in the open state. It changes only on the edge after a strobe, relock or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous reset, active high |
| op_done | input | 1 | one-cycle strobe: a dial operation has finished |
| op_dir | input | 1 | turn direction of the operation, 1 = right, 0 = left |
| op_val | input | VAL_W (6) | dial number at the end of the operation |
| relock | input | 1 | return to the locked idle state |
| unlocked | output | 1 | high while the lock is open |

## Verification
Every result of this controller is due exactly one edge after its cause. The strobe, relock or reset applied before an edge is reflected in `unlocked` right after that edge, because `unlocked` is a direct decode of the state register. The bench drives inputs on the falling edge. It samples `unlocked` 2 ns after the next rising edge. At that point it compares against a bench-side model stepped once for that same edge, so each check covers exactly one transition. Idle cycles with loaded dial values are also checked this way. Ignored inputs therefore show up at the next sample, not later.

// File: rtl/dial_lock_pkg.sv
package dial_lock_pkg;

   // Two-bit progress record; the numeric order is the order of the steps.
   typedef enum logic [1:0] {
      LK_IDLE   = 2'd0,
      LK_FIRST  = 2'd1,
      LK_SECOND = 2'd2,
      LK_OPEN   = 2'd3
   } lock_state_t;

   localparam int unsigned NUM_STEPS = 3;

   function automatic lock_state_t advance(input lock_state_t s);
      case (s)
         LK_IDLE:   return LK_FIRST;
         LK_FIRST:  return LK_SECOND;
         default:   return LK_OPEN;
      endcase
   endfunction

endpackage

// File: rtl/dial_step_match.sv
module dial_step_match #(
   parameter int unsigned          VAL_W     = 6,
   parameter int unsigned          NSTEP     = 3,
   parameter logic [NSTEP*VAL_W-1:0] EXP_VALS = '0,
   parameter logic [NSTEP-1:0]     EXP_DIRS  = '0
) (
   input  logic             op_dir,
   input  logic [VAL_W-1:0] op_val,
   output logic [NSTEP-1:0] hit
);

   // One comparator per secret step: direction and value must both agree.
   for (genvar g = 0; g < NSTEP; g++) begin : g_step
      localparam logic [VAL_W-1:0] KEY_VAL = EXP_VALS[g*VAL_W +: VAL_W];
      localparam logic             KEY_DIR = EXP_DIRS[g];
      assign hit[g] = (op_val == KEY_VAL) && (op_dir == KEY_DIR);
   end

endmodule

// File: rtl/dial_next_state.sv
module dial_next_state
   import dial_lock_pkg::*;
(
   input  lock_state_t        cur,
   input  logic [NUM_STEPS-1:0] hit,
   input  logic               op_done,
   input  logic               relock,
   output lock_state_t        nxt,
   output logic               load
);

   logic expected_hit;

   always_comb begin
      case (cur)
         LK_IDLE:   expected_hit = hit[0];
         LK_FIRST:  expected_hit = hit[1];
         LK_SECOND: expected_hit = hit[2];
         default:   expected_hit = 1'b0;
      endcase
   end

   always_comb begin
      load = op_done | relock;
      if (relock) begin
         nxt = LK_IDLE;
      end else if (cur == LK_OPEN) begin
         nxt = LK_OPEN;
      end else if (expected_hit) begin
         nxt = advance(cur);
      end else begin
         nxt = LK_IDLE;
      end
   end

endmodule

// File: rtl/dial_state_reg.sv
module dial_state_reg
   import dial_lock_pkg::*;
(
   input  logic        clk,
   input  logic        rst,
   input  logic        load,
   input  lock_state_t nxt,
   output lock_state_t cur
);

   always_ff @(posedge clk) begin
      if (rst) begin
         cur <= LK_IDLE;
      end else if (load) begin
         cur <= nxt;
      end
   end

   // R1: reset forces idle
   a_r1_reset_idle: assert property (@(posedge clk) rst |=> cur == LK_IDLE);

   // R7: no load request, no state change
   a_r7_hold_without_load: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(cur));

endmodule

// File: rtl/dial_lock_ctrl.sv
module dial_lock_ctrl
   import dial_lock_pkg::*;
#(
   parameter int unsigned VAL_W     = 6,
   parameter int unsigned STEP0_VAL = 13,
   parameter bit          STEP0_DIR = 1'b1,
   parameter int unsigned STEP1_VAL = 22,
   parameter bit          STEP1_DIR = 1'b0,
   parameter int unsigned STEP2_VAL = 3,
   parameter bit          STEP2_DIR = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             op_done,
   input  logic             op_dir,
   input  logic [VAL_W-1:0] op_val,
   input  logic             relock,
   output logic             unlocked
);

   localparam int unsigned VAL_LIMIT = 1 << VAL_W;
   localparam logic [NUM_STEPS*VAL_W-1:0] KEY_VALS =
      {VAL_W'(STEP2_VAL), VAL_W'(STEP1_VAL), VAL_W'(STEP0_VAL)};
   localparam logic [NUM_STEPS-1:0] KEY_DIRS = {STEP2_DIR, STEP1_DIR, STEP0_DIR};

   // Elaboration-time parameter checks
   if (VAL_W < 1 || VAL_W > 16) begin : g_bad_width
      $error("dial_lock_ctrl: VAL_W out of range");
   end
   if (STEP0_VAL >= VAL_LIMIT || STEP1_VAL >= VAL_LIMIT || STEP2_VAL >= VAL_LIMIT) begin : g_bad_key
      $error("dial_lock_ctrl: secret value does not fit VAL_W");
   end

   logic [NUM_STEPS-1:0] hit;
   lock_state_t          cur;
   lock_state_t          nxt;
   logic                 load;

   dial_step_match #(
      .VAL_W   (VAL_W),
      .NSTEP   (NUM_STEPS),
      .EXP_VALS(KEY_VALS),
      .EXP_DIRS(KEY_DIRS)
   ) u_match (
      .op_dir(op_dir),
      .op_val(op_val),
      .hit   (hit)
   );

   dial_next_state u_next (
      .cur    (cur),
      .hit    (hit),
      .op_done(op_done),
      .relock (relock),
      .nxt    (nxt),
      .load   (load)
   );

   dial_state_reg u_state (
      .clk (clk),
      .rst (rst),
      .load(load),
      .nxt (nxt),
      .cur (cur)
   );

   assign unlocked = (cur == LK_OPEN);

   // R2: final correct step from the second stage opens the lock
   a_r2_final_step_opens: assert property (@(posedge clk) disable iff (rst)
      (cur == LK_SECOND && op_done && hit[2] && !relock) |=> unlocked);

   // R5: mismatch after the first step drops to idle
   a_r5_first_mismatch: assert property (@(posedge clk) disable iff (rst)
      (cur == LK_FIRST && op_done && !hit[1] && !relock) |=> cur == LK_IDLE);

   // R5: mismatch after the second step drops to idle
   a_r5_second_mismatch: assert property (@(posedge clk) disable iff (rst)
      (cur == LK_SECOND && op_done && !hit[2] && !relock) |=> cur == LK_IDLE);

   // R6: mismatch while idle stays idle
   a_r6_idle_mismatch: assert property (@(posedge clk) disable iff (rst)
      (cur == LK_IDLE && op_done && !hit[0] && !relock) |=> cur == LK_IDLE);

   // R8: open state persists without relock
   a_r8_open_holds: assert property (@(posedge clk) disable iff (rst)
      (unlocked && !relock) |=> unlocked);

   // R9: relock always returns to idle
   a_r9_relock_idle: assert property (@(posedge clk) disable iff (rst)
      relock |=> (cur == LK_IDLE && !unlocked));

   // R10: opening is always caused by a strobe
   a_r10_open_cause: assert property (@(posedge clk) disable iff (rst)
      $rose(unlocked) |-> $past(op_done));

endmodule

// File: tb/sim_dial_lock_ctrl.sv
`timescale 1ns/1ps
module sim_dial_lock_ctrl;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       op_done = 1'b0;
   logic       op_dir = 1'b0;
   logic [5:0] op_val = '0;
   logic       relock = 1'b0;
   logic       unlocked;

   int n_checks = 0;
   int n_fail   = 0;
   int model    = 0;   // 0 idle, 1 first, 2 second, 3 open
   bit finished = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   dial_lock_ctrl u0 (
      .clk(clk), .rst(rst), .op_done(op_done), .op_dir(op_dir),
      .op_val(op_val), .relock(relock), .unlocked(unlocked)
   );

   function automatic int model_next(int st, bit rs, bit rl, bit dn, bit d, int v);
      if (rs) return 0;
      if (rl) return 0;
      if (!dn) return st;
      if (st == 3) return 3;
      case (st)
         0: return (d == 1'b1 && v == 13) ? 1 : 0;
         1: return (d == 1'b0 && v == 22) ? 2 : 0;
         default: return (d == 1'b1 && v == 3) ? 3 : 0;
      endcase
   endfunction

   task automatic check(string tag, logic act, logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: unlocked=%b expected=%b", tag, act, exp);
      end
   endtask

   // One cycle: drive on the falling edge, sample after the rising edge.
   task automatic cyc(string tag, bit rs, bit rl, bit dn, bit d, int v);
      @(negedge clk);
      rst = rs; relock = rl; op_done = dn; op_dir = d; op_val = 6'(v);
      model = model_next(model, rs, rl, dn, d, v);
      @(posedge clk);
      #2;
      check(tag, unlocked, model == 3);
   endtask

   task automatic op(string tag, bit d, int v);
      cyc(tag, 1'b0, 1'b0, 1'b1, d, v);
   endtask

   task automatic idle(string tag, bit d, int v);
      cyc(tag, 1'b0, 1'b0, 1'b0, d, v);
   endtask

   task automatic open_seq(string tag);
      op(tag, 1'b1, 13);
      op(tag, 1'b0, 22);
      op(tag, 1'b1, 3);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      // R1: reset state
      cyc("R1 reset", 1'b1, 1'b0, 1'b0, 1'b0, 0);
      cyc("R1 reset held", 1'b1, 1'b0, 1'b1, 1'b1, 13);
      idle("R1 after reset", 1'b0, 0);

      // R2: correct ordered sequence
      open_seq("R2 ordered sequence");
      check("R2 open reached", unlocked, 1'b1);

      // R9: relock from open
      cyc("R9 relock from open", 1'b0, 1'b1, 1'b0, 1'b0, 0);

      // R3: permuted orders
      op("R3 order L22 first", 1'b0, 22);
      op("R3 order R13", 1'b1, 13);
      op("R3 order R3", 1'b1, 3);
      check("R3 not open", unlocked, 1'b0);
      op("R3 order R3 first", 1'b1, 3);
      op("R3 then L22", 1'b0, 22);
      op("R3 then R13", 1'b1, 13);

      // R4: wrong direction on correct values
      cyc("R4 relock", 1'b0, 1'b1, 1'b0, 1'b0, 0);
      op("R4 R13", 1'b1, 13);
      op("R4 right 22 wrong dir", 1'b1, 22);
      op("R4 R3", 1'b1, 3);
      check("R4 not open", unlocked, 1'b0);

      // R5: mismatch at the last stage then the missing step alone
      op("R5 R13", 1'b1, 13);
      op("R5 L22", 1'b0, 22);
      op("R5 wrong value", 1'b1, 4);
      op("R5 R3 after drop", 1'b1, 3);
      check("R5 stays locked", unlocked, 1'b0);
      open_seq("R5 full retry");

      // R8: operations ignored when open
      op("R8 wrong op while open", 1'b0, 7);
      op("R8 step op while open", 1'b1, 13);
      check("R8 still open", unlocked, 1'b1);

      // R9: relock wins over simultaneous strobe
      cyc("R9 relock with strobe", 1'b0, 1'b1, 1'b1, 1'b1, 13);
      op("R9 L22 after relock", 1'b0, 22);
      op("R9 R3 after relock", 1'b1, 3);

      // R6: mismatches while idle
      op("R6 idle mismatch", 1'b0, 13);
      op("R6 idle mismatch 63", 1'b1, 63);
      open_seq("R6 sequence after idle mismatches");
      cyc("R9 relock", 1'b0, 1'b1, 1'b0, 1'b0, 0);

      // R7: dial values without strobe are ignored
      op("R7 R13", 1'b1, 13);
      idle("R7 idle wrong value", 1'b1, 50);
      idle("R7 idle next step value", 1'b0, 22);
      op("R7 L22", 1'b0, 22);
      idle("R7 idle final value", 1'b1, 3);
      check("R7 no open without strobe", unlocked, 1'b0);
      op("R7 R3", 1'b1, 3);

      // R1: reset from open
      cyc("R1 reset from open", 1'b1, 1'b0, 1'b0, 1'b0, 0);

      // R10: random mix
      for (int i = 0; i < 600; i++) begin
         bit rl = ($urandom % 25) == 0;
         bit dn = ($urandom % 3) != 0;
         bit d;
         int v;
         int pick = $urandom % 8;
         if (pick < 6) begin
            case (pick % 3)
               0: begin d = 1'b1; v = 13; end
               1: begin d = 1'b0; v = 22; end
               default: begin d = 1'b1; v = 3; end
            endcase
            if (($urandom % 6) == 0) d = ~d;
         end else begin
            d = 1'($urandom);
            v = $urandom % 64;
         end
         cyc("R10 random", 1'b0, rl, dn, d, v);
      end

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: unlocked=%b expected=done", unlocked);
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

endmodule